// File: doc/BRIEF.md
# Interrupt Source Router with Claim and Complete

This block gathers level-sensitive interrupt lines from up to 63 peripherals (source IDs 1 to 63; ID 0 is reserved and means "none") and reduces them to one external-interrupt request toward a single processor context. Software programs a per-source priority, a per-source enable and a context threshold through a simple 32-bit register bus. While a line is eligible, the request output stays high. The service routine reads the claim register to learn which source won. It runs the handler and then writes the same ID back to the claim register to mark the work as done.

Each source is tracked by its own three-state machine. `SRC_IDLE` means nothing is waiting. `SRC_PEND` means the level was seen and is waiting to be claimed. `SRC_SERV` means the source has been claimed and is masked until completion. The transitions are as follows:
- *raise*: IDLE→PEND when the level is high, or when software writes a 1 to the pending bit.
- *claim*: PEND→SERV when this source wins a claim read.
- *wipe*: PEND→IDLE when software writes a 0 to the pending bit.
- *complete*: SERV→IDLE when its ID is written to the claim register.

A software write to the pending bank gives a fallback way to clear requests without claim and complete. A combinational arbiter picks the winner among sources that are pending, enabled and above the threshold.

Top module: `intc_hub`

## Requirements
- R1: After reset, all priorities, enables and the threshold read 0, no source is pending or in service, `irq_o` is low, and a claim read returns 0.
- R2: Source n has a priority register at byte offset 4·n (n = 1..63). It holds 3 bits. Upper write bits are dropped and read back as 0. A write changes only the addressed source. Priority 0 never makes a source eligible.
- R3: A source is eligible when it is pending, its enable bit is 1, and its priority is strictly greater than the threshold. `irq_o` is high in the same cycle that any source is eligible.
- R4: Enable bits live in word 0x2080 for sources 1–31 (bit n) and in word 0x2084 for sources 32–63 (bit n−32). Bit 0 of word 0x2080 always reads 0. Writing 0 to both words blocks every request.
- R5: Among eligible sources, the winner is the one with the highest priority. On equal priority, the lowest ID wins.
- R6: A read of offset 0x201004 returns the winner's ID, clears its pending bit and puts it in service. It returns 0 and changes nothing when no source is eligible. If the claimed source was the only eligible one, `irq_o` is low from the next cycle.
- R7: A source in service ignores its level and its pending-bank bit until its own ID is written to offset 0x201004. A write of any other ID leaves it in service.
- R8: Every source level is sampled on each clock. A high level on an idle source sets its pending bit, and that bit stays set after the level falls.
- R9: Pending bits read at 0x1000 (sources 1–31, bit n) and 0x1004 (sources 32–63, bit n−32). A write to either word overwrites the pending bit of each source that is not in service, so writing 0 clears them.
- R10: The threshold register is at offset 0x201000, 3 bits wide, and reads back with upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 63 | Level interrupt inputs, bit n is source ID n (bits 63:1) |
| bus_addr | input | 22 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_re | input | 1 | Read strobe; needed for the claim side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | External interrupt request to the processor |

## Verification
On every cycle, the assertions check each source machine's moves: a claim puts the source in service, service holds until completion and blocks new pending, and a completion frees the source. They also check that a level latches, that a request is never raised with every enable cleared, and that a claim read with no request returns 0. The arbitration order, the exact register offsets and bit positions, the strict threshold comparison, and the fallback clear through the pending bank show up only in the bench's directed scenarios, because those depend on what software wrote earlier.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    // Register offsets (bytes)
    localparam int unsigned OFS_PEND   = 32'h0000_1000;
    localparam int unsigned OFS_EN     = 32'h0000_2080;
    localparam int unsigned OFS_THRESH = 32'h0020_1000;
    localparam int unsigned OFS_CLAIM  = 32'h0020_1004;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_PEND = 2'd1,
        SRC_SERV = 2'd2
    } src_state_t;
endpackage

// File: rtl/intc_src_fsm.sv
`timescale 1ns/1ps
module intc_src_fsm
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic sw_we_i,
    input  logic sw_val_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic serv_o
);
    src_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pend_o  = 1'b0;
        serv_o  = 1'b0;
        unique case (state_q)
            SRC_IDLE: begin
                if (sw_we_i)    state_d = sw_val_i ? SRC_PEND : SRC_IDLE;
                else if (lvl_i) state_d = SRC_PEND;
            end
            SRC_PEND: begin
                pend_o = 1'b1;
                if (claim_i)                   state_d = SRC_SERV;
                else if (sw_we_i && !sw_val_i) state_d = SRC_IDLE;
            end
            SRC_SERV: begin
                serv_o = 1'b1;
                if (done_i) state_d = SRC_IDLE;
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    a_r6_claim_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && pend_o) |=> serv_o);
    a_r7_service_blocks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (serv_o && !done_i) |=> (serv_o && !pend_o));
    a_r7_complete_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (serv_o && done_i) |=> !serv_o);
    a_r8_level_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !serv_o && lvl_i && !sw_we_i) |=> pend_o);
    a_r8_pending_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !claim_i && !sw_we_i) |=> pend_o);
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter #(
    parameter int N    = 63,
    parameter int PW   = 3,
    parameter int IDW  = 6
) (
    input  logic [N:1]    pend_i,
    input  logic [N:1]    en_i,
    input  logic [PW-1:0] prio_i [1:N],
    input  logic [PW-1:0] thresh_i,
    output logic [IDW-1:0] win_id_o,
    output logic           win_any_o
);
    logic [PW-1:0] best_p;

    // Ascending scan with strict compare: lowest ID keeps a tie.
    always_comb begin
        best_p   = thresh_i;
        win_id_o = '0;
        for (int i = 1; i <= N; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
                best_p   = prio_i[i];
                win_id_o = IDW'(i);
            end
        end
        win_any_o = (win_id_o != '0);
    end
endmodule

// File: rtl/intc_hub.sv
`timescale 1ns/1ps
module intc_hub
    import intc_pkg::*;
#(
    parameter int SRC_CNT = 63,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_CNT:1]    src_i,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq_o
);
    localparam int ID_W  = $clog2(SRC_CNT + 1);
    localparam int WORDS = (SRC_CNT + 32) / 32;
    localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFS_THRESH);
    localparam logic [ADDR_W-1:0] A_CLAIM  = ADDR_W'(OFS_CLAIM);

    logic [PRIO_W-1:0] prio_q [1:SRC_CNT];
    logic [SRC_CNT:1]  en_q;
    logic [PRIO_W-1:0] thresh_q;
    logic [SRC_CNT:1]  pend_vec, serv_vec, claim_vec, done_vec, sw_we_vec;
    logic [ID_W-1:0]   win_id;
    logic              win_any;

    // ---------------- address decode ----------------
    logic              prio_hit, en_hit, pend_hit, claim_rd, claim_wr;
    logic [ID_W-1:0]   prio_id;
    logic [ADDR_W-1:0] en_off, pend_off;
    logic [ADDR_W-3:0] en_sel, pend_sel;

    always_comb begin
        en_off   = bus_addr - A_EN;
        pend_off = bus_addr - A_PEND;
        en_sel   = en_off[ADDR_W-1:2];
        pend_sel = pend_off[ADDR_W-1:2];
        prio_id  = bus_addr[ID_W+1:2];
        prio_hit = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:ID_W+2] == '0)
                   && (prio_id != '0) && (int'(prio_id) <= SRC_CNT);
        en_hit   = (bus_addr[1:0] == 2'b00) && (bus_addr >= A_EN)
                   && (int'(en_sel) < WORDS);
        pend_hit = (bus_addr[1:0] == 2'b00) && (bus_addr >= A_PEND)
                   && (int'(pend_sel) < WORDS);
        claim_rd = bus_re && (bus_addr == A_CLAIM);
        claim_wr = bus_we && (bus_addr == A_CLAIM);
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= SRC_CNT; i++) prio_q[i] <= '0;
            en_q     <= '0;
            thresh_q <= '0;
        end else if (bus_we) begin
            for (int i = 1; i <= SRC_CNT; i++) begin
                if (prio_hit && (prio_id == ID_W'(i)))
                    prio_q[i] <= bus_wdata[PRIO_W-1:0];
                if (en_hit && (en_sel == (ADDR_W-2)'(i / 32)))
                    en_q[i] <= bus_wdata[i % 32];
            end
            if (bus_addr == A_THRESH) thresh_q <= bus_wdata[PRIO_W-1:0];
        end
    end

    // ---------------- per-source state machines ----------------
    for (genvar g = 1; g <= SRC_CNT; g++) begin : g_src
        assign claim_vec[g] = claim_rd && (win_id == ID_W'(g));
        assign done_vec[g]  = claim_wr && (bus_wdata == 32'(g));
        assign sw_we_vec[g] = bus_we && pend_hit && (pend_sel == (ADDR_W-2)'(g / 32));

        intc_src_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (src_i[g]),
            .sw_we_i  (sw_we_vec[g]),
            .sw_val_i (bus_wdata[g % 32]),
            .claim_i  (claim_vec[g]),
            .done_i   (done_vec[g]),
            .pend_o   (pend_vec[g]),
            .serv_o   (serv_vec[g])
        );
    end

    intc_arbiter #(.N(SRC_CNT), .PW(PRIO_W), .IDW(ID_W)) u_arb (
        .pend_i    (pend_vec),
        .en_i      (en_q),
        .prio_i    (prio_q),
        .thresh_i  (thresh_q),
        .win_id_o  (win_id),
        .win_any_o (win_any)
    );

    assign irq_o = win_any;

    // ---------------- read mux ----------------
    logic [31:0] pend_word [WORDS];
    logic [31:0] en_word   [WORDS];

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            pend_word[w] = '0;
            en_word[w]   = '0;
            for (int b = 0; b < 32; b++) begin
                if ((w * 32 + b) >= 1 && (w * 32 + b) <= SRC_CNT) begin
                    pend_word[w][b] = pend_vec[w * 32 + b];
                    en_word[w][b]   = en_q[w * 32 + b];
                end
            end
        end
        bus_rdata = '0;
        if (prio_hit)                    bus_rdata = 32'(prio_q[prio_id]);
        else if (pend_hit)               bus_rdata = pend_word[int'(pend_sel)];
        else if (en_hit)                 bus_rdata = en_word[int'(en_sel)];
        else if (bus_addr == A_THRESH)   bus_rdata = 32'(thresh_q);
        else if (bus_addr == A_CLAIM)    bus_rdata = 32'(win_id);
    end

    a_r6_idle_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !irq_o) |-> (bus_rdata == 32'd0));
    a_r4_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);
    a_r3_irq_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_vec & en_q) != '0));
    a_r7_claim_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec & pend_vec));
endmodule

// File: tb/intc_hub_bench.sv
`timescale 1ns/1ps
module intc_hub_bench;
    localparam logic [21:0] A_PEND0  = 22'h001000;
    localparam logic [21:0] A_PEND1  = 22'h001004;
    localparam logic [21:0] A_EN0    = 22'h002080;
    localparam logic [21:0] A_EN1    = 22'h002084;
    localparam logic [21:0] A_THRESH = 22'h201000;
    localparam logic [21:0] A_CLAIM  = 22'h201004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:1] src = '0;
    logic [21:0] addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intc_hub u_intc_hub (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_we(we), .bus_re(re), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [21:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [21:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; re = 1'b1;
        #2 d = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(22'h000050, d); check("R1 prio reset", d, 0);
        rd(A_EN0, d);      check("R1 enable reset", d, 0);
        rd(A_PEND0, d);    check("R1 pending reset", d, 0);
        rd(A_THRESH, d);   check("R1 threshold reset", d, 0);
        rd(A_CLAIM, d);    check("R1 claim reset", d, 0);
        check("R1 irq reset", {31'b0, irq}, 0);
    endtask

    task automatic t_config_and_eligibility;
        logic [31:0] d;
        wr(A_EN0, 32'h0010_0001);
        rd(A_EN0, d); check("R4 enable bit20, bit0 reserved", d, 32'h0010_0000);
        rd(A_EN1, d); check("R4 second enable word untouched", d, 0);
        @(negedge clk); src[20] = 1'b1;
        idle(1);
        rd(A_PEND0, d); check("R8 level sets pending bit20", d, 32'h0010_0000);
        check("R2 priority 0 never eligible", {31'b0, irq}, 0);
        wr(22'h000050, 32'hFFFF_FFFF);
        rd(22'h000050, d); check("R2 priority 3-bit readback", d, 7);
        rd(22'h000054, d); check("R2 neighbour priority untouched", d, 0);
        check("R3 irq with prio 7 > thr 0", {31'b0, irq}, 1);
        wr(A_THRESH, 32'h0000_00FF);
        rd(A_THRESH, d); check("R10 threshold 3-bit readback", d, 7);
        check("R3 prio equal to threshold blocked", {31'b0, irq}, 0);
        wr(A_THRESH, 6);
        check("R3 prio above threshold fires", {31'b0, irq}, 1);
        wr(A_THRESH, 0);
    endtask

    task automatic t_claim_complete;
        logic [31:0] d;
        rd(A_CLAIM, d); check("R6 claim returns 20", d, 20);
        check("R6 irq low after claim", {31'b0, irq}, 0);
        rd(A_PEND0, d); check("R6 claim clears pending", d, 0);
        wr(A_PEND0, 32'h0010_0000);
        rd(A_PEND0, d); check("R7 pending write ignored in service", d, 0);
        wr(A_CLAIM, 21);
        idle(1);
        rd(A_PEND0, d); check("R7 wrong ID does not complete", d, 0);
        wr(A_CLAIM, 20);
        idle(1);
        rd(A_PEND0, d); check("R7 completion re-arms source", d, 32'h0010_0000);
        @(negedge clk); src[20] = 1'b0;
        idle(2);
        rd(A_PEND0, d); check("R8 pending latched after level drop", d, 32'h0010_0000);
        rd(A_CLAIM, d); check("R6 second claim returns 20", d, 20);
        wr(A_CLAIM, 20);
        check("R6 nothing left", {31'b0, irq}, 0);
    endtask

    task automatic t_arbitration;
        logic [31:0] d;
        wr(22'h00000C, 2);
        wr(22'h0000A0, 5);
        wr(22'h0000A4, 5);
        wr(A_EN0, 32'h0000_0008);
        wr(A_EN1, 32'h0000_0300);
        @(negedge clk); src[3] = 1'b1; src[40] = 1'b1; src[41] = 1'b1;
        @(negedge clk); src[3] = 1'b0; src[40] = 1'b0; src[41] = 1'b0;
        rd(A_PEND1, d); check("R9 pending word 2 bits 8,9", d, 32'h0000_0300);
        rd(A_CLAIM, d); check("R5 tie goes to lowest ID 40", d, 40);
        rd(A_CLAIM, d); check("R5 next highest 41", d, 41);
        rd(A_CLAIM, d); check("R5 lower priority 3 last", d, 3);
        rd(A_CLAIM, d); check("R6 empty claim returns 0", d, 0);
        check("R6 irq low when all in service", {31'b0, irq}, 0);
        wr(A_CLAIM, 40); wr(A_CLAIM, 41); wr(A_CLAIM, 3);
        rd(A_PEND1, d); check("R7 completions leave nothing pending", d, 0);
    endtask

    task automatic t_soft_pending;
        logic [31:0] d;
        wr(22'h0000B4, 1);
        wr(A_EN1, 32'h0000_2000);
        wr(A_PEND1, 32'h0000_2000);
        check("R9 software set raises irq", {31'b0, irq}, 1);
        rd(A_PEND1, d); check("R9 pending readback source 45", d, 32'h0000_2000);
        wr(A_PEND1, 0);
        check("R9 software clear drops irq", {31'b0, irq}, 0);
        wr(A_PEND1, 32'h0000_2000);
        wr(A_EN1, 0);
        check("R4 disable blocks irq", {31'b0, irq}, 0);
        rd(A_CLAIM, d); check("R6 claim with no eligible source", d, 0);
        rd(A_PEND1, d); check("R6 empty claim leaves pending", d, 32'h0000_2000);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_config_and_eligibility();
        t_claim_complete();
        t_arbitration();
        t_soft_pending();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule